// File: doc/BRIEF.md
# Fused Add-Multiply Unit

This block returns the product of a sum and a third operand, Z = (A + B) · X, with all three inputs in two's complement. It does not first add A and B with a carry-propagate adder and then multiply. Instead, a recoding stage turns the pair of addends directly into signed radix-4 digits, each in the range −2 to +2. The carries that the recoder uses travel at most one digit position. Each digit selects 0, X or 2X, and negates it when the digit is negative. The rows are sign-extended to the full product width. A single correction row collects the +1 that each negated row still needs. A Wallace-style tree of 3:2 compressors reduces all rows to two, and one final adder resolves them.

The unit has a simple valid handshake with one cycle of latency. The operands and `in_valid` are presented in one cycle. The product and `out_valid` appear after the next rising clock edge. A new operand set can be accepted every cycle. When no valid operands arrive, the output register keeps its last result.

Top module: `fam_unit`

## Requirements
- R1: `out_valid` equals the value that `in_valid` had one clock earlier, so every accepted operand set yields exactly one flagged result one cycle later.
- R2: When `in_valid` is high at a rising edge, then after that edge `out_z` holds (A + B) · X as a two's-complement number of 2·WIDTH+2 bits, where A, B and X are the signed values of `in_a`, `in_b` and `in_x`. Back-to-back operand sets produce back-to-back results in order.
- R3: At an edge where `in_valid` is low, `out_z` keeps its value, whatever the operand inputs carry.
- R4: A synchronous active-high `rst` sets `out_valid` to 0 and `out_z` to all zeros, even when `in_valid` is high in the same cycle.
- R5: The product is exact for the most negative operand values, including the case where A, B and X are all the most negative code.
- R6: A zero multiplicand X, or A = B = 0, gives a result of zero.
- R7: A = −B gives a result of zero for every X.
- R8: The radix-4 digits are formed from A and B without resolving their sum. Each digit lies in −2..+2, and the digits, weighted by powers of four, equal A + B at its full WIDTH+1-bit precision. This holds even when the sum does not fit in WIDTH bits, and the product is correct in that case too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `in_a`, `in_b` and `in_x` are valid this cycle |
| in_a | input | WIDTH | First addend, two's complement |
| in_b | input | WIDTH | Second addend, two's complement |
| in_x | input | WIDTH | Multiplicand, two's complement |
| out_valid | output | 1 | `out_z` carries a fresh result |
| out_z | output | 2·WIDTH+2 | Registered product (A+B)·X, two's complement |

## Verification
A fault in the recoder, such as a carry routed to the wrong digit or a wrong sign bit, shows up in `out_z` on the very next cycle. It appears only for the operand pairs whose bits exercise that path, which is why the bench sweeps every combination of a small configuration rather than sampling. A missing correction bit or a misplaced row shift offsets the product by a multiple of a power of four whenever a digit is negative or nonzero. Faults in the handshake or the hold behaviour show as `out_valid` or `out_z` disagreeing with the previous cycle's `in_valid` at the first idle or reset cycle.

// File: rtl/fam_pkg.sv
package fam_pkg;

    // One signed radix-4 digit: magnitude one-hot (one / two), sign separate.
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } mb_digit_t;

    // Sign-extended addend width: even, and wide enough for A+B.
    function automatic int sum_width(input int w);
        return (w % 2 == 0) ? w + 2 : w + 1;
    endfunction

    function automatic int num_digits(input int w);
        return sum_width(w) / 2;
    endfunction

    function automatic int prod_width(input int w);
        return 2 * w + 2;
    endfunction

    // Rows left after a number of 3:2 compression levels.
    function automatic int rows_at(input int r0, input int lvl);
        int r;
        r = r0;
        for (int i = 0; i < lvl; i++) begin
            r = r - r / 3;
        end
        return r;
    endfunction

    // Levels needed to bring r0 rows down to two.
    function automatic int tree_depth(input int r0);
        int r;
        int d;
        r = r0;
        d = 0;
        while (r > 2) begin
            r = r - r / 3;
            d++;
        end
        return d;
    endfunction

    // Digit value = s0 + e - 2*ng, mapped to sign and one-hot magnitude.
    function automatic mb_digit_t mb_encode(input logic s0, input logic ng, input logic e);
        mb_digit_t d;
        d.one = s0 ^ e;
        d.two = (s0 & e & ~ng) | (~s0 & ~e & ng);
        d.neg = ng & ~(s0 & e);
        return d;
    endfunction

    function automatic int digit_value(input mb_digit_t d);
        int v;
        v = d.two ? 2 : (d.one ? 1 : 0);
        return d.neg ? -v : v;
    endfunction

endpackage

// File: rtl/fam_sum_recoder.sv
module fam_sum_recoder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output fam_pkg::mb_digit_t digits [fam_pkg::num_digits(WIDTH)]
);
    localparam int SW = fam_pkg::sum_width(WIDTH);
    localparam int ND = SW / 2;

    logic [SW-1:0] ax;
    logic [SW-1:0] bx;
    // carry from the high bit pair of the digit below, into the low-bit adder
    logic [ND-1:0] cv;
    // transfer from the middle position of the digit below, at weight 1
    logic [ND-1:0] ev;

    assign ax = {{(SW-WIDTH){a[WIDTH-1]}}, a};
    assign bx = {{(SW-WIDTH){b[WIDTH-1]}}, b};
    assign cv[0] = 1'b0;
    assign ev[0] = 1'b0;

    for (genvar j = 0; j < ND; j++) begin : g_dig
        logic s0;
        logic k;
        logic h;
        logic ng;

        // full adder on the low bit pair with the neighbour carry
        assign s0 = ax[2*j] ^ bx[2*j] ^ cv[j];
        assign k  = (ax[2*j] & bx[2*j]) | (cv[j] & (ax[2*j] ^ bx[2*j]));
        // half adder on the high bit pair
        assign h  = ax[2*j+1] ^ bx[2*j+1];
        // 2*(h+k) split into -2*ng here and a transfer of weight 4 upward
        assign ng = h ^ k;

        assign digits[j] = fam_pkg::mb_encode(s0, ng, ev[j]);

        if (j < ND - 1) begin : g_up
            assign cv[j+1] = ax[2*j+1] & bx[2*j+1];
            assign ev[j+1] = h | k;
        end
    end

endmodule

// File: rtl/fam_pp_gen.sv
module fam_pp_gen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   x,
    input  fam_pkg::mb_digit_t digits [fam_pkg::num_digits(WIDTH)],
    output logic [fam_pkg::prod_width(WIDTH)-1:0] rows [fam_pkg::num_digits(WIDTH)+1]
);
    localparam int PW = fam_pkg::prod_width(WIDTH);
    localparam int ND = fam_pkg::num_digits(WIDTH);

    logic [PW-1:0] xe;
    logic [PW-1:0] corr;

    assign xe = {{(PW-WIDTH){x[WIDTH-1]}}, x};

    for (genvar j = 0; j < ND; j++) begin : g_row
        logic [PW-1:0] mag;

        always_comb begin
            if (digits[j].two) begin
                mag = xe << 1;
            end else if (digits[j].one) begin
                mag = xe;
            end else begin
                mag = '0;
            end
        end

        // ones' complement here; the +1 goes into the correction row
        assign rows[j] = (digits[j].neg ? ~mag : mag) << (2 * j);
    end

    always_comb begin
        corr = '0;
        for (int j = 0; j < ND; j++) begin
            corr[2*j] = digits[j].neg;
        end
    end

    assign rows[ND] = corr;

endmodule

// File: rtl/fam_csa.sv
module fam_csa #(
    parameter int PW = 18
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    input  logic [PW-1:0] z,
    output logic [PW-1:0] sum,
    output logic [PW-1:0] carry
);
    assign sum   = x ^ y ^ z;
    assign carry = {(x[PW-2:0] & y[PW-2:0]) |
                    (x[PW-2:0] & z[PW-2:0]) |
                    (y[PW-2:0] & z[PW-2:0]), 1'b0};
endmodule

// File: rtl/fam_csa_tree.sv
module fam_csa_tree #(
    parameter int PW    = 18,
    parameter int NROWS = 6
) (
    input  logic [PW-1:0] rows_i [NROWS],
    output logic [PW-1:0] row_s,
    output logic [PW-1:0] row_c
);
    localparam int NLEV = fam_pkg::tree_depth(NROWS);

    for (genvar l = 0; l < NLEV; l++) begin : g_lvl
        localparam int RI = fam_pkg::rows_at(NROWS, l);
        localparam int RO = fam_pkg::rows_at(NROWS, l + 1);
        localparam int NG = RI / 3;

        logic [PW-1:0] src [RI];
        logic [PW-1:0] dst [RO];

        for (genvar i = 0; i < RI; i++) begin : g_src
            if (l == 0) begin : g_first
                assign src[i] = rows_i[i];
            end else begin : g_next
                assign src[i] = g_lvl[l-1].dst[i];
            end
        end

        for (genvar g = 0; g < NG; g++) begin : g_csa
            fam_csa #(.PW(PW)) u_csa (
                .x     (src[3*g]),
                .y     (src[3*g+1]),
                .z     (src[3*g+2]),
                .sum   (dst[2*g]),
                .carry (dst[2*g+1])
            );
        end

        for (genvar p = 0; p < RI - 3 * NG; p++) begin : g_pass
            assign dst[2*NG+p] = src[3*NG+p];
        end
    end

    if (NLEV == 0) begin : g_flat
        assign row_s = rows_i[0];
        assign row_c = rows_i[1];
    end else begin : g_tail
        assign row_s = g_lvl[NLEV-1].dst[0];
        assign row_c = g_lvl[NLEV-1].dst[1];
    end

endmodule

// File: rtl/fam_unit.sv
module fam_unit #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     in_a,
    input  logic [WIDTH-1:0]     in_b,
    input  logic [WIDTH-1:0]     in_x,
    output logic                 out_valid,
    output logic [2*WIDTH+1:0]   out_z
);
    localparam int PW = fam_pkg::prod_width(WIDTH);
    localparam int ND = fam_pkg::num_digits(WIDTH);
    localparam int NR = ND + 1;

    fam_pkg::mb_digit_t digits [ND];
    logic [PW-1:0]      pp_rows [NR];
    logic [PW-1:0]      row_s;
    logic [PW-1:0]      row_c;

    fam_sum_recoder #(.WIDTH(WIDTH)) u_rec (
        .a      (in_a),
        .b      (in_b),
        .digits (digits)
    );

    fam_pp_gen #(.WIDTH(WIDTH)) u_pp (
        .x      (in_x),
        .digits (digits),
        .rows   (pp_rows)
    );

    fam_csa_tree #(.PW(PW), .NROWS(NR)) u_tree (
        .rows_i (pp_rows),
        .row_s  (row_s),
        .row_c  (row_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_z     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_z <= row_s + row_c;
            end
        end
    end

endmodule

// File: rtl/fam_unit_chk.sv
module fam_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [WIDTH-1:0]     in_a,
    input logic [WIDTH-1:0]     in_b,
    input logic [WIDTH-1:0]     in_x,
    input logic                 out_valid,
    input logic [2*WIDTH+1:0]   out_z,
    input fam_pkg::mb_digit_t   digits [fam_pkg::num_digits(WIDTH)]
);
    localparam int PW = fam_pkg::prod_width(WIDTH);
    localparam int SW = fam_pkg::sum_width(WIDTH);
    localparam int ND = SW / 2;

    logic signed [PW-1:0]   ea, eb, ex, ref_z;
    logic signed [SW+1:0]   absum, dsum;

    assign ea    = PW'($signed(in_a));
    assign eb    = PW'($signed(in_b));
    assign ex    = PW'($signed(in_x));
    assign ref_z = (ea + eb) * ex;
    assign absum = (SW+2)'($signed(in_a)) + (SW+2)'($signed(in_b));

    always_comb begin
        dsum = '0;
        for (int j = 0; j < ND; j++) begin
            dsum = dsum + ((SW+2)'(fam_pkg::digit_value(digits[j])) <<< (2 * j));
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    product_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_z == $past(ref_z)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_z));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_z == '0));

    // R8
    digit_sum_chk: assert property (@(posedge clk) disable iff (rst)
        dsum == absum);

    for (genvar j = 0; j < ND; j++) begin : g_dchk
        // R8
        digit_mag_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({digits[j].one, digits[j].two}));
        // R8
        digit_sign_chk: assert property (@(posedge clk) disable iff (rst)
            digits[j].neg |-> (digits[j].one || digits[j].two));
    end

endmodule

bind fam_unit fam_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_z     (out_z),
    .digits    (digits)
);

// File: tb/fam_unit_tb.sv
module fam_unit_tb;
    localparam int TW   = 4;
    localparam int PW   = 2 * TW + 2;
    localparam int MINV = -(1 << (TW - 1));
    localparam int MAXV = (1 << (TW - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [TW-1:0] in_a = '0;
    logic [TW-1:0] in_b = '0;
    logic [TW-1:0] in_x = '0;
    logic          out_valid;
    logic [PW-1:0] out_z;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fam_unit #(.WIDTH(TW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_z     (out_z)
    );

    function automatic logic [PW-1:0] model(input int a, input int b, input int x);
        int p;
        p = (a + b) * x;
        return PW'(p);
    endfunction

    function automatic string tag_of(input int a, input int b, input int x);
        if ((a == MINV && b == MINV) || x == MINV) return "R5";
        if (x == 0 || (a == 0 && b == 0))         return "R6";
        if (a + b == 0)                           return "R7";
        if (a + b > MAXV || a + b < MINV)         return "R8";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int a, input int b, input int x, input logic v);
        in_a     = a[TW-1:0];
        in_b     = b[TW-1:0];
        in_x     = x[TW-1:0];
        in_valid = v;
    endtask

    initial begin
        int pa = 0;
        int pb = 0;
        int px = 0;
        bit have = 1'b0;
        logic [PW-1:0] last;

        // R4: reset state
        repeat (3) @(negedge clk);
        check("R4", 64'(out_valid), 64'd0);
        check("R4", 64'(out_z), 64'd0);
        rst = 1'b0;

        // R2 R5 R6 R7 R8: every operand combination, one per cycle
        for (int a = MINV; a <= MAXV; a++) begin
            for (int b = MINV; b <= MAXV; b++) begin
                for (int x = MINV; x <= MAXV; x++) begin
                    @(negedge clk);
                    if (have) begin
                        check("R1", 64'(out_valid), 64'd1);
                        check(tag_of(pa, pb, px), 64'(out_z), 64'(model(pa, pb, px)));
                    end
                    drive(a, b, x, 1'b1);
                    pa = a; pb = b; px = x;
                    have = 1'b1;
                end
            end
        end
        @(negedge clk);
        check("R1", 64'(out_valid), 64'd1);
        check(tag_of(pa, pb, px), 64'(out_z), 64'(model(pa, pb, px)));
        last = model(pa, pb, px);

        // R3: idle cycles with changing operands keep the result
        for (int i = 0; i < 4; i++) begin
            drive(i + 1, -i - 2, MINV + i, 1'b0);
            @(negedge clk);
            check("R1", 64'(out_valid), 64'd0);
            check("R3", 64'(out_z), 64'(last));
        end

        // R7: cancelling addends after an idle gap
        drive(MAXV, -MAXV, MINV, 1'b1);
        @(negedge clk);
        check("R1", 64'(out_valid), 64'd1);
        check("R7", 64'(out_z), 64'd0);

        // R5: all operands most negative
        drive(MINV, MINV, MINV, 1'b1);
        @(negedge clk);
        check("R5", 64'(out_z), 64'(model(MINV, MINV, MINV)));

        // R4: reset mid-stream wins over in_valid
        drive(3, 2, -3, 1'b1);
        @(negedge clk);
        check("R2", 64'(out_z), 64'(model(3, 2, -3)));
        rst = 1'b1;
        @(negedge clk);
        check("R4", 64'(out_valid), 64'd0);
        check("R4", 64'(out_z), 64'd0);
        rst = 1'b0;
        drive(5, 6, 7, 1'b0);
        @(negedge clk);
        check("R4", 64'(out_valid), 64'd0);
        check("R3", 64'(out_z), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule